// File: doc/BRIEF.md
# Alarm-Sequenced Power-Enable Controller

This block owns the enable line of an external power regulator. It turns the system off by waiting for a second alarm. A timekeeping core compares its current time against a set of alarm-2 compare fields and sends a match pulse to this block. When that match arrives together with the one-second update tick, the controller latches an alarm-2 status flag. It can also raise an interrupt from that flag. If software has armed power control, the controller drops the enable line on the same event.

The line comes back on only when a wakeup input reaches its active level. There are up to four wakeup inputs, and each one can be enabled on its own. Each input also has its own polarity. The inputs are resynchronised inside the block and are not debounced.

Software reaches the block through a 32-bit write port with a small register select:

| Select | Register | Fields |
|---|---|---|
| 0 | Power control | bit 16 arms power-off on alarm 2; bits [3:0] enable the wakeup inputs; bits [7:4] set input polarity |
| 1 | Status | writing 1 to bit 7 clears the alarm-2 flag |
| 2 | Interrupt enable | bit 4 enables the alarm-2 interrupt |

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: After reset the design is in this state.
  - `pmic_en_o` is 1.
  - `alarm2_sts_o` and `irq_o` are 0.
  - All configuration bits are 0.
- R2: An alarm-2 event is `alarm2_match_i` and `sec_tick_i` both high in the same cycle. A match without the tick is ignored. An event sets `alarm2_sts_o` at the next clock edge.
- R3: The alarm-2 flag is set whether or not the interrupt is enabled. `irq_o` equals the flag ANDed with interrupt-enable bit 4, which is written with `wr_sel_i`=2.
- R4: The flag clears on a write with `wr_sel_i`=1 and data bit 7 = 1. A write with bit 7 = 0 leaves the flag unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R5: With control bit 16 set (`wr_sel_i`=0), an alarm-2 event drives `pmic_en_o` low at the next edge. With bit 16 clear, the event leaves `pmic_en_o` unchanged.
- R6: Control bits [3:0] enable wakeup inputs 0 to 3. Bits [7:4] set the polarity of inputs 0 to 3: 1 means active-low and 0 means active-high.
  - An enabled input at its active level sets `pmic_en_o` high.
  - This happens on the third clock edge after the pin changes: two synchroniser stages, then the output register.
- R7: A wakeup input whose enable bit is clear has no effect on `pmic_en_o`.
- R8: If a power-off event and an active enabled wakeup fall in the same cycle, `pmic_en_o` goes low at that edge. It then returns high at the next edge if the wakeup is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable |
| wr_data_i | input | 32 | Write data |
| alarm2_match_i | input | 1 | Alarm-2 compare match from the time core |
| sec_tick_i | input | 1 | One-second update tick |
| wake_i | input | 4 | Asynchronous wakeup pins |
| pmic_en_o | output | 1 | Power-enable output to the regulator |
| irq_o | output | 1 | Alarm-2 interrupt |
| alarm2_sts_o | output | 1 | Alarm-2 status flag |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is an alarm event and a status-clear write. The bench drives the match, the tick and a bit-7 status write at one falling edge. It expects the flag to stay set.

The second pair is a power-off event and a wakeup. The bench holds an enabled wakeup pin active while the alarm fires. It expects `pmic_en_o` to be low for exactly one cycle and then high again.

Random phases overlap all of these with config writes. The bench judges every cycle against a per-cycle model of the flag, the enable line and the two synchroniser stages.

// File: rtl/pmic_pwr_pkg.sv
package pmic_pwr_pkg;
  typedef enum logic [1:0] {
    SEL_PWR = 2'd0,
    SEL_STS = 2'd1,
    SEL_IRQ = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAKE-1:0] pins_i,
  input  logic [NUM_WAKE-1:0] en_i,
  input  logic [NUM_WAKE-1:0] pol_i,
  output logic                act_any_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_WAKE-1:0] stg_q [SYNC_STAGES];
  logic [NUM_WAKE-1:0] act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SYNC_STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= pins_i;
      for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  // pol=1: active-low
  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
    assign act[i] = en_i[i] & (stg_q[LAST][i] ^ pol_i[i]);
  end

  assign act_any_o = |act;
endmodule

// File: rtl/alarm2_status.sv
module alarm2_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_q <= 1'b0;
    else if (evt_i) sts_q <= 1'b1;   // set wins over clear
    else if (clr_i) sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & irq_en_i;

  a_r2_evt_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> sts_o);
  a_r4_clear_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !sts_o);
endmodule

// File: rtl/pwr_en_ctl.sv
module pwr_en_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic off_evt_i,
  input  logic wake_any_i,
  output logic pmic_en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= 1'b1;
    else if (off_evt_i)  en_q <= 1'b0;
    else if (wake_any_i) en_q <= 1'b1;
  end

  assign pmic_en_o = en_q;

  a_r5_off_on_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_evt_i |=> !pmic_en_o);
  a_r6_rise_needs_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pmic_en_o) |-> $past(wake_any_i));
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl
  import pmic_pwr_pkg::*;
#(
  parameter int NUM_WAKE    = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PWR_CTL_BIT = 16,
  parameter int STS_CLR_BIT = 7,
  parameter int IRQ_EN_BIT  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                alarm2_match_i,
  input  logic                sec_tick_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  output logic                pmic_en_o,
  output logic                irq_o,
  output logic                alarm2_sts_o
);
  localparam int POL_LSB = NUM_WAKE;
  localparam int POL_MSB = 2 * NUM_WAKE - 1;

  logic                pwr_ctl_q, irq_en_q;
  logic [NUM_WAKE-1:0] wake_en_q, wake_pol_q;
  logic                wr_pwr, wr_sts, wr_irq;
  logic                alarm_evt, sts_clr, wake_any;

  assign wr_pwr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_PWR);
  assign wr_sts = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STS);
  assign wr_irq = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_ctl_q  <= 1'b0;
      wake_en_q  <= '0;
      wake_pol_q <= '0;
      irq_en_q   <= 1'b0;
    end else begin
      if (wr_pwr) begin
        pwr_ctl_q  <= wr_data_i[PWR_CTL_BIT];
        wake_en_q  <= wr_data_i[NUM_WAKE-1:0];
        wake_pol_q <= wr_data_i[POL_MSB:POL_LSB];
      end
      if (wr_irq) irq_en_q <= wr_data_i[IRQ_EN_BIT];
    end
  end

  assign alarm_evt = alarm2_match_i & sec_tick_i;
  assign sts_clr   = wr_sts & wr_data_i[STS_CLR_BIT];

  wake_detect #(.NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (wake_i),
    .en_i     (wake_en_q),
    .pol_i    (wake_pol_q),
    .act_any_o(wake_any)
  );

  alarm2_status u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (alarm_evt),
    .clr_i   (sts_clr),
    .irq_en_i(irq_en_q),
    .sts_o   (alarm2_sts_o),
    .irq_o   (irq_o)
  );

  pwr_en_ctl u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .off_evt_i (alarm_evt & pwr_ctl_q),
    .wake_any_i(wake_any),
    .pmic_en_o (pmic_en_o)
  );

  a_r2_match_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm2_match_i && !sec_tick_i && !alarm2_sts_o) |=> !alarm2_sts_o);
  a_r7_no_wake_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_en_q == '0 && !pmic_en_o) |=> !pmic_en_o);
endmodule

// File: tb/tb_pmic_pwr_ctrl.sv
module tb_pmic_pwr_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [31:0] wr_data_i;
  logic        alarm2_match_i, sec_tick_i;
  logic [3:0]  wake_i;
  logic        pmic_en_o, irq_o, alarm2_sts_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic       m_pwr, m_irqen, m_sts, m_en;
  logic [3:0] m_wen, m_pol, m_s1, m_s2;

  always #5 clk_i = ~clk_i;

  pmic_pwr_ctrl dut (.*);

  function automatic logic wake_active(logic [3:0] en, logic [3:0] pol, logic [3:0] s);
    return |(en & (s ^ pol));
  endfunction

  function automatic logic next_sts(logic sts, logic evt, logic clr);
    return evt ? 1'b1 : (clr ? 1'b0 : sts);
  endfunction

  function automatic logic next_en(logic en, logic off, logic act);
    return off ? 1'b0 : (act ? 1'b1 : en);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [1:0] sel, logic [31:0] d,
                      logic match, logic tick, logic [3:0] pins);
    logic act, evt;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    alarm2_match_i = match; sec_tick_i = tick; wake_i = pins;
    @(posedge clk_i);
    act = wake_active(m_wen, m_pol, m_s2);
    evt = match & tick;
    m_sts = next_sts(m_sts, evt, we && sel == 2'd1 && d[7]);
    m_en  = next_en(m_en, evt & m_pwr, act);
    if (we && sel == 2'd0) begin
      m_pwr = d[16]; m_wen = d[3:0]; m_pol = d[7:4];
    end
    if (we && sel == 2'd2) m_irqen = d[4];
    m_s2 = m_s1; m_s1 = pins;
    @(negedge clk_i);
    chk(tag, "pmic_en_o", pmic_en_o, m_en);
    chk(tag, "alarm2_sts_o", alarm2_sts_o, m_sts);
    chk(tag, "irq_o", irq_o, m_sts & m_irqen);
  endtask

  task automatic idle(string tag, logic [3:0] pins, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, pins);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_ni = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
    alarm2_match_i = 0; sec_tick_i = 0; wake_i = 0;
    m_pwr = 0; m_irqen = 0; m_sts = 0; m_en = 1; m_wen = 0; m_pol = 0; m_s1 = 0; m_s2 = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    // R1 reset state
    chk("R1", "pmic_en_o", pmic_en_o, 1'b1);
    chk("R1", "alarm2_sts_o", alarm2_sts_o, 1'b0);
    chk("R1", "irq_o", irq_o, 1'b0);

    // R5 arm power-off, no wakes enabled
    step("R5", 1, 2'd0, 32'h0001_0000, 0, 0, 4'h0);
    // R2 match without tick ignored
    step("R2", 0, 0, 0, 1, 0, 4'h0);
    chk("R2", "flag after match without tick", alarm2_sts_o, 1'b0);
    // R3/R5 event with irq disabled
    step("R3", 0, 0, 0, 1, 1, 4'h0);
    chk("R3", "flag set with irq off", alarm2_sts_o, 1'b1);
    chk("R3", "irq masked", irq_o, 1'b0);
    chk("R5", "power off", pmic_en_o, 1'b0);
    step("R3", 1, 2'd2, 32'h10, 0, 0, 4'h0);
    chk("R3", "irq after enable", irq_o, 1'b1);
    // R4 clear semantics
    step("R4", 1, 2'd1, 32'h7f, 0, 0, 4'h0);
    chk("R4", "bit7=0 keeps flag", alarm2_sts_o, 1'b1);
    step("R4", 1, 2'd1, 32'h80, 0, 0, 4'h0);
    chk("R4", "bit7=1 clears flag", alarm2_sts_o, 1'b0);
    step("R4", 1, 2'd1, 32'h80, 1, 1, 4'h0);
    chk("R4", "set wins over clear", alarm2_sts_o, 1'b1);
    // R7 pins toggling while disabled
    idle("R7", 4'hf, 4);
    idle("R7", 4'h0, 4);
    chk("R7", "disabled wake no effect", pmic_en_o, 1'b0);
    // R6 active-high input 0, latency
    step("R6", 1, 2'd0, 32'h0001_0001, 0, 0, 4'h0);
    step("R6", 0, 0, 0, 0, 0, 4'h1);
    step("R6", 0, 0, 0, 0, 0, 4'h1);
    chk("R6", "not yet on after two edges", pmic_en_o, 1'b0);
    step("R6", 0, 0, 0, 0, 0, 4'h1);
    chk("R6", "on at third edge", pmic_en_o, 1'b1);
    // R8 collision: wake held active while alarm fires
    step("R8", 0, 0, 0, 1, 1, 4'h1);
    chk("R8", "off wins same cycle", pmic_en_o, 1'b0);
    step("R8", 0, 0, 0, 0, 0, 4'h1);
    chk("R8", "wake reasserts next", pmic_en_o, 1'b1);
    // R6 active-low input 2
    step("R6", 1, 2'd0, 32'h0001_0044, 0, 0, 4'h4);
    idle("R6", 4'h4, 3);
    step("R6", 0, 0, 0, 1, 1, 4'h4);
    chk("R6", "off, pin inactive high", pmic_en_o, 1'b0);
    idle("R6", 4'h0, 3);
    chk("R6", "active-low wake", pmic_en_o, 1'b1);
    // R5 bit16 clear: event leaves enable high
    step("R5", 1, 2'd0, 32'h0, 0, 0, 4'h0);
    step("R5", 0, 0, 0, 1, 1, 4'h0);
    chk("R5", "no power-off when unarmed", pmic_en_o, 1'b1);

    // random phase, all requirements R2..R8 via model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R2-R8 random", (r[1:0] == 0), 2'($urandom % 3), $urandom,
           (r[4:2] == 0), r[5], r[11:8]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule